// File: doc/BRIEF.md
# Serial Transmitter with Holding Buffer and Ready Flags

This block is the sending half of a programmable serial port. A processor writes one character at a time into a single-entry holding buffer. Whenever the shift register reaches a character boundary and sending is allowed, the buffered character moves into the shift register. It is then sent on the serial output one bit at a time, with bit changes timed by falling edges of an external transmit clock. The block runs on a fast system clock, and the transmit clock is sampled as an ordinary input.

Two framings are offered. Asynchronous framing wraps each character in a start bit, an optional parity bit and one or two stop bits. Between characters the line rests at 1, and the transmit clock runs at 1, 16 or 64 times the bit rate. Synchronous framing sends only data and parity at one bit per transmit clock, with no gaps. When the processor falls behind, the block fills the gap with a programmable sync character.

A ready flag is offered in two forms. The status copy always reports whether the holding buffer is empty. The pin copy is additionally gated by the clear-to-send input and the transmit enable. An empty indication reports an idle shift register in asynchronous mode, and pulses once for every sync character inserted in synchronous mode.

Top module: `usart_tx_core`

## Requirements
- R1: After reset, txd is 1, txe is 1, txrdy_stat is 1, the buffer is empty, and txrdy_pin equals tx_en AND NOT cts_n.
- R2: In asynchronous mode (cfg_sync=0), a character is sent as one 0 bit, then the low 5+cfg_len data bits least significant first (cfg_len 0..3 gives 5..8 bits, and higher written bits are dropped), then the parity bit if enabled, then one stop bit of value 1, or two when cfg_stop2=1. Between characters txd is 1.
- R3: With cfg_par_en=1, the parity bit makes the count of ones over data plus parity even when cfg_par_odd=0 and odd when cfg_par_odd=1.
- R4: txd changes only after a falling edge of txc. Each asynchronous bit lasts 1, 16 or 64 txc periods for cfg_rate 0, 1 or 2/3. In synchronous mode each bit lasts one txc period.
- R5: A buffered character enters the shift register only at a character boundary while tx_en=1 and cts_n=0. Otherwise it stays buffered and txd stays at rest.
- R6: txrdy_stat is 1 exactly when the holding buffer is empty, whatever tx_en and cts_n are.
- R7: txrdy_pin is an internal ready flag ANDed with tx_en and NOT cts_n. The flag sets when a character moves from the buffer into the shift register, and clears on an accepted data write or on a cmd_wr pulse.
- R8: A data write while the buffer is full is ignored: the character already held is the one sent, and no extra character follows.
- R9: In asynchronous mode, txe is 1 from the end of the last bit of a character, or from reset, until a character moves into the shift register.
- R10: In synchronous mode, at each boundary with no character ready to load, sync_char is sent framed like data (data bits plus parity). txe is high for exactly one system clock at each such insertion, whatever tx_en is.
- R11: In synchronous mode, buffered characters are sent back to back with no sync character between them as long as the buffer is refilled in time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_sync | input | 1 | 1 selects synchronous framing |
| cfg_rate | input | 2 | Asynchronous txc periods per bit: 0 gives 1, 1 gives 16, 2/3 give 64 |
| cfg_len | input | 2 | Data bits minus 5 |
| cfg_par_en | input | 1 | Parity bit enabled |
| cfg_par_odd | input | 1 | 1 selects odd parity, 0 selects even |
| cfg_stop2 | input | 1 | Two stop bits in asynchronous mode |
| sync_char | input | 8 | Fill character for synchronous underrun |
| tx_en | input | 1 | Transmit enable command bit |
| cts_n | input | 1 | Clear to send, active low |
| cmd_wr | input | 1 | One-clock pulse marking a command write |
| wr_valid | input | 1 | One-clock data write strobe |
| wr_data | input | 8 | Character to send |
| txc | input | 1 | Transmit bit clock |
| txd | output | 1 | Serial data out |
| txrdy_pin | output | 1 | Gated ready flag |
| txrdy_stat | output | 1 | Holding buffer empty |
| txe | output | 1 | Transmitter empty, or sync insertion pulse |

## Verification
Asynchronous characters are decoded at three clock ratios with different lengths, parity senses and stop counts. A wrong bit order, parity sense, length mask or ratio therefore shows up as a changed decoded value. A blocked-then-released sequence with a second write while full separates gating faults from overwrite faults. A command pulse on an empty buffer separates the pin flag from the status bit. In synchronous mode, an idle run with the enable off checks fill content and single-clock empty pulses. Then two back-to-back writes check that data replaces fill and that no fill is wedged between characters.

// File: rtl/usart_tx_pkg.sv
package usart_tx_pkg;

    localparam int DATA_W  = 8;
    localparam int FRAME_W = 12;
    localparam int CNT_W   = $clog2(FRAME_W + 1);

    typedef struct packed {
        logic       sync_mode;
        logic [1:0] len;
        logic       par_en;
        logic       par_odd;
        logic       stop2;
    } frame_cfg_t;

    typedef struct packed {
        logic [FRAME_W-1:0] bits;
        logic [CNT_W-1:0]   cnt;
    } frame_t;

    // Lays a character out as the bit sequence to send, bit 0 first.
    function automatic frame_t build_frame(input logic [DATA_W-1:0] d,
                                           input frame_cfg_t c);
        frame_t            f;
        int                n;
        int                off;
        int                total;
        logic [DATA_W-1:0] m;
        logic              p;
        n     = 5 + int'(c.len);
        off   = c.sync_mode ? 0 : 1;
        m     = d & ((DATA_W'(1) << n) - DATA_W'(1));
        p     = (^m) ^ c.par_odd;
        f.bits = '1;
        if (!c.sync_mode) begin
            f.bits[0] = 1'b0;
        end
        for (int i = 0; i < DATA_W; i++) begin
            if (i < n) begin
                f.bits[i + off] = m[i];
            end
        end
        if (c.par_en) begin
            f.bits[n + off] = p;
        end
        total = n + off + (c.par_en ? 1 : 0);
        if (!c.sync_mode) begin
            total = total + 1 + (c.stop2 ? 1 : 0);
        end
        f.cnt = CNT_W'(total);
        return f;
    endfunction

endpackage

// File: rtl/utx_baud.sv
module utx_baud #(
    parameter int DIV_MID = 16,
    parameter int DIV_HI  = 64
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       txc,
    input  logic       sync_mode,
    input  logic [1:0] rate,
    output logic       tick
);
    localparam int CW = $clog2(DIV_HI);

    typedef struct packed {
        logic          txc;
        logic [CW-1:0] cnt;
    } baud_st_t;

    baud_st_t st_d, st_q;
    logic          fall;
    logic [CW-1:0] last;

    always_comb begin
        st_d = st_q;
        fall = st_q.txc & ~txc;
        if (sync_mode || rate == 2'd0) begin
            last = '0;
        end else if (rate == 2'd1) begin
            last = CW'(DIV_MID - 1);
        end else begin
            last = CW'(DIV_HI - 1);
        end
        tick     = fall && (st_q.cnt >= last);
        st_d.txc = txc;
        if (fall) begin
            st_d.cnt = tick ? '0 : st_q.cnt + CW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{txc: 1'b1, cnt: '0};
        end else begin
            st_q <= st_d;
        end
    end

    // R4: bit ticks come from txc falling edges, never two clocks in a row
    a_r4_tick_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);

endmodule

// File: rtl/utx_hold.sv
module utx_hold #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_valid,
    input  logic [DW-1:0] wr_data,
    input  logic          cmd_wr,
    input  logic          load,
    output logic          hold_valid,
    output logic [DW-1:0] hold_data,
    output logic          rdy_flag
);
    typedef struct packed {
        logic          valid;
        logic [DW-1:0] data;
        logic          flag;
    } hold_st_t;

    hold_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (load) begin
            st_d.valid = 1'b0;
            st_d.flag  = 1'b1;
        end
        if (wr_valid && !st_q.valid) begin
            st_d.valid = 1'b1;
            st_d.data  = wr_data;
            st_d.flag  = 1'b0;
        end
        if (cmd_wr) begin
            st_d.flag = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{valid: 1'b0, data: '0, flag: 1'b1};
        end else begin
            st_q <= st_d;
        end
    end

    assign hold_valid = st_q.valid;
    assign hold_data  = st_q.data;
    assign rdy_flag   = st_q.flag;

    // R5: the shifter only takes a character that is really held
    a_r5_load_needs_data: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> st_q.valid);
    // R8: a write into a full buffer leaves the held character alone
    a_r8_keep_on_full: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.valid && wr_valid && !load) |=> $stable(st_q.data));
    // R7: the ready flag never claims readiness while a character waits
    a_r7_flag_implies_empty: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.flag |-> !st_q.valid);

endmodule

// File: rtl/utx_shifter.sv
module utx_shifter
    import usart_tx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  frame_cfg_t        cfg,
    input  logic              go,
    input  logic              hold_valid,
    input  logic [DATA_W-1:0] hold_data,
    input  logic [DATA_W-1:0] sync_char,
    output logic              load,
    output logic              txd,
    output logic              txe
);
    typedef struct packed {
        logic [FRAME_W-1:0] shreg;
        logic [CNT_W-1:0]   left;
        logic               txd;
        logic               txe;
    } shf_st_t;

    shf_st_t st_d, st_q;
    frame_t  fr;

    always_comb begin
        st_d = st_q;
        load = 1'b0;
        fr   = '0;
        if (cfg.sync_mode) begin
            st_d.txe = 1'b0;
        end
        if (tick) begin
            if (st_q.left != '0) begin
                st_d.txd   = st_q.shreg[0];
                st_d.shreg = {1'b1, st_q.shreg[FRAME_W-1:1]};
                st_d.left  = st_q.left - CNT_W'(1);
            end else if ((hold_valid && go) || cfg.sync_mode) begin
                if (hold_valid && go) begin
                    fr       = build_frame(hold_data, cfg);
                    load     = 1'b1;
                    st_d.txe = 1'b0;
                end else begin
                    fr       = build_frame(sync_char, cfg);
                    st_d.txe = 1'b1;
                end
                st_d.txd   = fr.bits[0];
                st_d.shreg = {1'b1, fr.bits[FRAME_W-1:1]};
                st_d.left  = fr.cnt - CNT_W'(1);
            end else begin
                st_d.txd = 1'b1;
                st_d.txe = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{shreg: '1, left: '0, txd: 1'b1, txe: 1'b1};
        end else begin
            st_q <= st_d;
        end
    end

    assign txd = st_q.txd;
    assign txe = st_q.txe;

    // R4: the line only moves on a bit tick
    a_r4_txd_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(st_q.txd));
    // R9: asynchronous empty means no bits are left to send
    a_r9_txe_means_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg.sync_mode && st_q.txe) |-> (st_q.left == '0));
    // R2: an idle asynchronous line rests at 1
    a_r2_idle_marking: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg.sync_mode && st_q.txe) |-> st_q.txd);
    // R10: a sync insertion pulse lasts one clock
    a_r10_txe_single: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg.sync_mode && st_q.txe) |=> !st_q.txe);

endmodule

// File: rtl/usart_tx_core.sv
module usart_tx_core
    import usart_tx_pkg::*;
#(
    parameter int DIV_MID = 16,
    parameter int DIV_HI  = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_sync,
    input  logic [1:0]        cfg_rate,
    input  logic [1:0]        cfg_len,
    input  logic              cfg_par_en,
    input  logic              cfg_par_odd,
    input  logic              cfg_stop2,
    input  logic [DATA_W-1:0] sync_char,
    input  logic              tx_en,
    input  logic              cts_n,
    input  logic              cmd_wr,
    input  logic              wr_valid,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              txc,
    output logic              txd,
    output logic              txrdy_pin,
    output logic              txrdy_stat,
    output logic              txe
);
    frame_cfg_t        fcfg;
    logic              tick;
    logic              load;
    logic              go;
    logic              hold_valid;
    logic [DATA_W-1:0] hold_data;
    logic              rdy_flag;

    assign fcfg = '{sync_mode: cfg_sync, len: cfg_len, par_en: cfg_par_en,
                    par_odd: cfg_par_odd, stop2: cfg_stop2};
    assign go   = tx_en & ~cts_n;

    utx_baud #(.DIV_MID(DIV_MID), .DIV_HI(DIV_HI)) baud_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .txc       (txc),
        .sync_mode (cfg_sync),
        .rate      (cfg_rate),
        .tick      (tick)
    );

    utx_hold #(.DW(DATA_W)) hold_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_valid   (wr_valid),
        .wr_data    (wr_data),
        .cmd_wr     (cmd_wr),
        .load       (load),
        .hold_valid (hold_valid),
        .hold_data  (hold_data),
        .rdy_flag   (rdy_flag)
    );

    utx_shifter shf_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (tick),
        .cfg        (fcfg),
        .go         (go),
        .hold_valid (hold_valid),
        .hold_data  (hold_data),
        .sync_char  (sync_char),
        .load       (load),
        .txd        (txd),
        .txe        (txe)
    );

    assign txrdy_stat = ~hold_valid;
    assign txrdy_pin  = rdy_flag & go;

    // R7: the gated pin never shows ready while clear-to-send is off
    a_r7_pin_gated: assert property (@(posedge clk) disable iff (!rst_n)
        cts_n |-> !txrdy_pin);
    // R6: the pin copy is never set while the status copy is clear
    a_r6_pin_within_stat: assert property (@(posedge clk) disable iff (!rst_n)
        txrdy_pin |-> txrdy_stat);

endmodule

// File: tb/usart_tx_core_tb_top.sv
module usart_tx_core_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int TXC_HALF   = 2;
    localparam int TXC_CLKS   = 2 * TXC_HALF;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_sync = 1'b0;
    logic [1:0] cfg_rate = 2'd0;
    logic [1:0] cfg_len = 2'd3;
    logic       cfg_par_en = 1'b0;
    logic       cfg_par_odd = 1'b0;
    logic       cfg_stop2 = 1'b0;
    logic [7:0] sync_char = 8'h16;
    logic       tx_en = 1'b0;
    logic       cts_n = 1'b1;
    logic       cmd_wr = 1'b0;
    logic       wr_valid = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       txc = 1'b1;
    logic       txd, txrdy_pin, txrdy_stat, txe;

    int checks = 0;
    int failures = 0;
    int cyc = 0;

    usart_tx_core dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_sync(cfg_sync), .cfg_rate(cfg_rate),
        .cfg_len(cfg_len), .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd),
        .cfg_stop2(cfg_stop2), .sync_char(sync_char), .tx_en(tx_en),
        .cts_n(cts_n), .cmd_wr(cmd_wr), .wr_valid(wr_valid), .wr_data(wr_data),
        .txc(txc), .txd(txd), .txrdy_pin(txrdy_pin), .txrdy_stat(txrdy_stat),
        .txe(txe)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // txc generation and synchronous-mode bit capture share one process
    logic [63:0] hist = '0;
    logic [7:0]  snap = '0;
    logic [7:0]  snap2 = '0;
    int          pulses = 0;
    int          txe_hi = 0;
    int          ph = 0;
    bit          samp_pend = 1'b0;

    always @(negedge clk) begin
        if (samp_pend) begin
            samp_pend = 1'b0;
            if (cfg_sync) begin
                if (txe) begin
                    snap  = hist[63:56];
                    snap2 = hist[55:48];
                    pulses++;
                end
                hist = {txd, hist[63:1]};
            end
        end
        if (cfg_sync && txe) txe_hi++;
        ph++;
        if (ph >= TXC_HALF) begin
            ph  = 0;
            txc = ~txc;
            if (!txc) samp_pend = 1'b1;
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            failures++;
            $display("FAIL watchdog actual=%0d expected<=150000", cyc);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic write_byte(input logic [7:0] b);
        @(negedge clk);
        wr_valid = 1'b1;
        wr_data  = b;
        @(negedge clk);
        wr_valid = 1'b0;
    endtask

    task automatic rx_async(input int div, input int n, input bit par, input bit two,
                            output int st, output int data, output int p,
                            output int s1, output int s2);
        int bc;
        bc = div * TXC_CLKS;
        data = 0; p = 0; s2 = 1;
        while (txd !== 1'b0) @(negedge clk);
        repeat (bc/2) @(negedge clk);
        st = int'(txd);
        for (int i = 0; i < n; i++) begin
            repeat (bc) @(negedge clk);
            data = data | (int'(txd) << i);
        end
        if (par) begin
            repeat (bc) @(negedge clk);
            p = int'(txd);
        end
        repeat (bc) @(negedge clk);
        s1 = int'(txd);
        if (two) begin
            repeat (bc) @(negedge clk);
            s2 = int'(txd);
        end
    endtask

    task automatic run_async(input string tag, input logic [1:0] rate, input int div,
                             input logic [1:0] len, input bit par, input bit odd,
                             input bit two, input logic [7:0] b,
                             input int exp_d, input int exp_p);
        int st, d, p, s1, s2;
        cfg_sync = 1'b0; cfg_rate = rate; cfg_len = len;
        cfg_par_en = par; cfg_par_odd = odd; cfg_stop2 = two;
        write_byte(b);
        chk({tag, " R6 stat after write"}, int'(txrdy_stat), 0);
        chk({tag, " R7 pin after write"}, int'(txrdy_pin), 0);
        rx_async(div, 5 + int'(len), par, two, st, d, p, s1, s2);
        chk({tag, " R2 start bit"}, st, 0);
        chk({tag, " R2 data"}, d, exp_d);
        if (par) chk({tag, " R3 parity"}, p, exp_p);
        chk({tag, " R2 stop1"}, s1, 1);
        if (two) chk({tag, " R2 stop2"}, s2, 1);
        chk({tag, " R6 stat after load"}, int'(txrdy_stat), 1);
        chk({tag, " R7 pin after load"}, int'(txrdy_pin), 1);
        chk({tag, " R9 txe busy"}, int'(txe), 0);
        repeat (div * TXC_CLKS) @(negedge clk);
        chk({tag, " R9 txe idle"}, int'(txe), 1);
        chk({tag, " R2 idle mark"}, int'(txd), 1);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 txd", int'(txd), 1);
        chk("R1 txe", int'(txe), 1);
        chk("R1 stat", int'(txrdy_stat), 1);
        chk("R1 pin disabled", int'(txrdy_pin), 0);
        tx_en = 1'b1; cts_n = 1'b0;
        @(negedge clk);
        chk("R1 R7 pin enabled", int'(txrdy_pin), 1);
    endtask

    task automatic t_rate16_start();
        int w;
        cfg_sync = 1'b0; cfg_rate = 2'd1; cfg_len = 2'd3; cfg_par_en = 1'b0; cfg_stop2 = 1'b0;
        write_byte(8'h01);
        while (txd !== 1'b0) @(negedge clk);
        w = 0;
        while (txd === 1'b0) begin
            w++;
            @(negedge clk);
        end
        chk("R4 x16 start width", w, 16 * TXC_CLKS);
        repeat (10 * 16 * TXC_CLKS) @(negedge clk);
    endtask

    task automatic t_gate();
        int lows, st, d, p, s1, s2;
        cfg_sync = 1'b0; cfg_rate = 2'd0; cfg_len = 2'd3; cfg_par_en = 1'b0; cfg_stop2 = 1'b0;
        cts_n = 1'b1;
        @(negedge clk);
        chk("R7 pin off with cts high", int'(txrdy_pin), 0);
        chk("R6 stat with cts high", int'(txrdy_stat), 1);
        write_byte(8'h3C);
        lows = 0;
        repeat (200) begin
            @(negedge clk);
            if (txd !== 1'b1) lows++;
        end
        chk("R5 held while blocked", lows, 0);
        chk("R5 still buffered", int'(txrdy_stat), 0);
        write_byte(8'hC3);
        cts_n = 1'b0;
        rx_async(1, 8, 1'b0, 1'b0, st, d, p, s1, s2);
        chk("R8 first byte kept", d, 8'h3C);
        lows = 0;
        repeat (20 * TXC_CLKS) begin
            @(negedge clk);
            if (txd !== 1'b1) lows++;
        end
        chk("R8 no extra frame", lows, 0);
        chk("R8 buffer empty", int'(txrdy_stat), 1);
    endtask

    task automatic t_cmd();
        int st, d, p, s1, s2;
        chk("R7 pin before cmd", int'(txrdy_pin), 1);
        @(negedge clk);
        cmd_wr = 1'b1;
        @(negedge clk);
        cmd_wr = 1'b0;
        chk("R7 pin cleared by cmd", int'(txrdy_pin), 0);
        chk("R6 stat unaffected by cmd", int'(txrdy_stat), 1);
        write_byte(8'h55);
        rx_async(1, 8, 1'b0, 1'b0, st, d, p, s1, s2);
        chk("R7 pin back after load", int'(txrdy_pin), 1);
        chk("R2 cmd byte", d, 8'h55);
        repeat (4 * TXC_CLKS) @(negedge clk);
    endtask

    task automatic t_sync();
        int p0, h0;
        tx_en = 1'b0;
        cfg_len = 2'd3; cfg_par_en = 1'b0; sync_char = 8'h16;
        cfg_sync = 1'b1;
        while (pulses < 3) @(negedge clk);
        p0 = pulses; h0 = txe_hi;
        repeat (8 * 8 * TXC_CLKS) @(negedge clk);
        chk("R10 fill count", pulses - p0, 8);
        chk("R10 pulse width", txe_hi - h0, pulses - p0);
        chk("R10 fill content", int'(snap), 8'h16);
        tx_en = 1'b1;
        p0 = pulses;
        while (pulses == p0) @(negedge clk);
        write_byte(8'h9A);
        while (txrdy_stat !== 1'b1) @(negedge clk);
        write_byte(8'h3E);
        p0 = pulses;
        while (pulses == p0) @(negedge clk);
        chk("R11 second byte", int'(snap), 8'h3E);
        chk("R11 first byte adjacent", int'(snap2), 8'h9A);
        p0 = pulses;
        while (pulses == p0) @(negedge clk);
        chk("R10 fill resumes", int'(snap), 8'h16);
    endtask

    initial begin
        t_reset();
        run_async("8N1x1", 2'd0, 1, 2'd3, 1'b0, 1'b0, 1'b0, 8'hA5, 8'hA5, 0);
        run_async("7Ex16", 2'd1, 16, 2'd2, 1'b1, 1'b0, 1'b0, 8'h35, 8'h35, 0);
        run_async("5O2x64", 2'd2, 64, 2'd0, 1'b1, 1'b1, 1'b1, 8'hFB, 8'h1B, 1);
        run_async("6E1x1", 2'd0, 1, 2'd1, 1'b1, 1'b0, 1'b0, 8'h29, 8'h29, 1);
        t_rate16_start();
        t_gate();
        t_cmd();
        t_sync();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule